// File: doc/BRIEF.md
# Paged Audio-Controller Register File

This block holds the software-visible registers of a three-channel audio controller: two playback channels (DAC1, DAC2) and one capture channel (ADC). A host reaches it through a 256-byte window using byte, halfword or word accesses, with little-endian lane numbering. Partial writes replace only the addressed byte lanes of a 32-bit register. Every access whose low byte falls in 0x30–0x3F is redirected through a 4-bit page register into a 12-bit space, where the per-channel frame address and frame count registers are located.

The block drives one interrupt line. Each channel has a pending flag. The attached channel engine sets a flag by pulsing `eng_done`, and only while that channel's interrupt enable is set. A serial-control write that clears an enable also clears that channel's flag. The control word, the serial-control word and every per-channel counter register are presented to the channel engine as plain outputs. Reads are combinational from an address captured at the access edge.

The host interface is a plain strobe with no back-pressure. Every access with `bus_valid` high is accepted in the cycle it is presented. Read data is valid from the edge that accepts the read until the next read is accepted.

Top module: `audio_regfile`

## Requirements
- R1: After reset, control reads 0x00000001, status reads 0x00000060, and the page, codec and serial-control registers read 0. `irq` is low.
- R2: Word offsets are: control 0x00, status 0x04, page 0x0C, codec 0x10, serial control 0x20, and sample counters at 0x24 (DAC1), 0x28 (DAC2) and 0x2C (ADC).
- R3: `bus_size` encodes 0 = byte, 1 = halfword and 2 = word. Write data sits in the low bits of `bus_wdata`. A byte or halfword write to control, serial control or codec replaces only the addressed lanes. A read returns the addressed lanes shifted down to bit 0, with the upper bits zero.
- R4: When the low address byte is 0x30–0x3F, the effective address is that byte ORed with the page register shifted left by 8. Frame address and frame count sit at 0xC30/0xC34 (DAC1), 0xC38/0xC3C (DAC2) and 0xD30/0xD34 (ADC).
- R5: The page register keeps only the low 4 bits of a write.
- R6: A write to a sample counter changes only its low 16 bits.
- R7: Channel pending flags appear in status at bit 2 (DAC1), bit 1 (DAC2) and bit 0 (ADC). Status bit 31 and `irq` are the OR of these flags. An `eng_done[i]` pulse (index 0 = DAC1, 1 = DAC2, 2 = ADC) sets a flag only when its serial-control enable is 1. These enables are bit 8 (DAC1), bit 9 (DAC2) and bit 10 (ADC).
- R8: A serial-control write that takes a channel's enable from 1 to 0 clears that channel's pending flag.
- R9: Reads of unmapped addresses, including 0xD38 and 0xD3C, return all ones. Writes to those addresses, and any write to status, change no register.
- R10: A byte read at 0x1B returns 0x05.
- R11: `ctl_o`, `sctl_o` and the per-channel counter outputs always show the current register contents. Channel 0 is in the lowest 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, accepted the same cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 8 | Byte address in the window |
| bus_wdata | input | 32 | Write data, low-aligned |
| rd_data | output | 32 | Read data for the last accepted read |
| eng_done | input | 3 | Per-channel completion pulses from the engine |
| irq | output | 1 | Interrupt line |
| ctl_o | output | 32 | Control register |
| sctl_o | output | 32 | Serial-control register |
| ch_scount | output | 96 | Sample counters, 32 bits per channel |
| ch_faddr | output | 96 | Frame addresses, 32 bits per channel |
| ch_fcnt | output | 96 | Frame counts, 32 bits per channel |

## Verification
A wrong page value or a bad window decode shows at once: the next read in 0x30–0x3F returns the wrong channel's frame register, or all ones, and the channel outputs change on the wrong write. A stuck or wrongly cleared pending flag shows on `irq` one cycle after the pulse or after the serial-control write. It also shows on the next status read. Lane-merge errors show on the first read after a partial write, because the bench compares neighbouring lanes that must not change.

// File: rtl/audreg_pkg.sv
package audreg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_STAT   = 12'h004;
  localparam logic [11:0] OFS_PAGE   = 12'h00C;
  localparam logic [11:0] OFS_CODEC  = 12'h010;
  localparam logic [11:0] OFS_SCTL   = 12'h020;
  localparam logic [11:0] OFS_MAGIC  = 12'h01B;

  function automatic logic [11:0] sc_ofs(input int c);
    return 12'(12'h024 + 4 * c);
  endfunction

  function automatic logic [11:0] fa_ofs(input int c);
    return 12'(12'hC30 + (c / 2) * 256 + (c % 2) * 8);
  endfunction

  function automatic logic [LANES-1:0] lane_en(input logic [1:0] size, input logic [1:0] a);
    case (size)
      SZ_BYTE: lane_en = 4'b0001 << a;
      SZ_HALF: lane_en = a[1] ? 4'b1100 : 4'b0011;
      default: lane_en = 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [LANES-1:0] be);
    for (int b = 0; b < LANES; b++)
      merge[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
  endfunction

endpackage

// File: rtl/audreg_addr_fold.sv
module audreg_addr_fold #(
  parameter int          PAGE_W   = 4,
  parameter logic [7:0]  WIN_BASE = 8'h30,
  localparam int         EFF_W    = 8 + PAGE_W
) (
  input  logic [7:0]        addr,
  input  logic [PAGE_W-1:0] page,
  output logic [EFF_W-1:0]  eff
);
  logic in_win;
  assign in_win = (addr[7:4] == WIN_BASE[7:4]);
  assign eff    = in_win ? {page, addr} : {{PAGE_W{1'b0}}, addr};
endmodule

// File: rtl/audreg_chan.sv
module audreg_chan
  import audreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sc,
  input  logic              wr_fa,
  input  logic              wr_fc,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] scount,
  output logic [DATA_W-1:0] faddr,
  output logic [DATA_W-1:0] fcnt
);
  localparam logic [LANES-1:0] SC_LANES = LANES'(4'b0011);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scount <= '0;
      faddr  <= '0;
      fcnt   <= '0;
    end else begin
      if (wr_sc) scount <= merge(scount, wdata, be & SC_LANES);
      if (wr_fa) faddr  <= merge(faddr, wdata, be);
      if (wr_fc) fcnt   <= merge(fcnt, wdata, be);
    end
  end
endmodule

// File: rtl/audreg_pend.sv
module audreg_pend #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_pulse,
  input  logic [NUM_CH-1:0] en_now,
  input  logic [NUM_CH-1:0] en_fall,
  output logic [NUM_CH-1:0] pend,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (en_fall[i])                     pend[i] <= 1'b0;
        else if (set_pulse[i] && en_now[i]) pend[i] <= 1'b1;
      end
    end
  end

  assign irq = |pend;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_clear_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall[g] |=> !pend[g]);
    p_set_needs_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(set_pulse[g] && en_now[g]));
  end

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(set_pulse & en_now)));
endmodule

// File: rtl/audio_regfile.sv
module audio_regfile
  import audreg_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int PAGE_W   = 4,
  parameter int EN_BIT0  = 8,
  localparam int EFF_W   = 8 + PAGE_W,
  localparam int CH_W    = NUM_CH * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  input  logic [NUM_CH-1:0] eng_done,
  output logic              irq,
  output logic [31:0]       ctl_o,
  output logic [31:0]       sctl_o,
  output logic [CH_W-1:0]   ch_scount,
  output logic [CH_W-1:0]   ch_faddr,
  output logic [CH_W-1:0]   ch_fcnt
);
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] ctl_q, sctl_q, codec_q, sctl_nx, stat_w;
  logic [EFF_W-1:0]  eff, weff, rd_eff_q;
  logic [1:0]        rd_size_q;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wsh;
  logic              wr, wr_ctl, wr_sctl, wr_codec, wr_page;
  logic [NUM_CH-1:0] pend, en_now, en_fall;
  logic [DATA_W-1:0] sc_w [NUM_CH];
  logic [DATA_W-1:0] fa_w [NUM_CH];
  logic [DATA_W-1:0] fc_w [NUM_CH];

  audreg_addr_fold #(.PAGE_W(PAGE_W)) u_fold (
    .addr(bus_addr), .page(page_q), .eff(eff));

  assign weff     = {eff[EFF_W-1:2], 2'b00};
  assign be       = lane_en(bus_size, eff[1:0]);
  assign wsh      = bus_wdata << {eff[1:0], 3'b000};
  assign wr       = bus_valid && bus_write;
  assign wr_ctl   = wr && (weff == OFS_CTRL);
  assign wr_sctl  = wr && (weff == OFS_SCTL);
  assign wr_codec = wr && (weff == OFS_CODEC);
  assign wr_page  = wr && (weff == OFS_PAGE);
  assign sctl_nx  = merge(sctl_q, wsh, be);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= 32'h0000_0001;
      sctl_q    <= '0;
      codec_q   <= '0;
      page_q    <= '0;
      rd_eff_q  <= '0;
      rd_size_q <= SZ_WORD;
    end else begin
      if (wr_ctl)   ctl_q   <= merge(ctl_q, wsh, be);
      if (wr_sctl)  sctl_q  <= sctl_nx;
      if (wr_codec) codec_q <= merge(codec_q, wsh, be);
      if (wr_page)  page_q  <= PAGE_W'(merge(DATA_W'(page_q), wsh, be));
      if (bus_valid && !bus_write) begin
        rd_eff_q  <= eff;
        rd_size_q <= bus_size;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign en_now[c]  = sctl_q[EN_BIT0 + c];
    assign en_fall[c] = wr_sctl && sctl_q[EN_BIT0 + c] && !sctl_nx[EN_BIT0 + c];
    audreg_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_sc(wr && weff == sc_ofs(c)),
      .wr_fa(wr && weff == fa_ofs(c)),
      .wr_fc(wr && weff == fa_ofs(c) + 12'd4),
      .be(be), .wdata(wsh),
      .scount(sc_w[c]), .faddr(fa_w[c]), .fcnt(fc_w[c]));
    assign ch_scount[DATA_W*c +: DATA_W] = sc_w[c];
    assign ch_faddr [DATA_W*c +: DATA_W] = fa_w[c];
    assign ch_fcnt  [DATA_W*c +: DATA_W] = fc_w[c];
  end

  audreg_pend #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_pulse(eng_done), .en_now(en_now),
    .en_fall(en_fall), .pend(pend), .irq(irq));

  always_comb begin
    stat_w = 32'h0000_0060;
    stat_w[31] = irq;
    for (int i = 0; i < NUM_CH; i++) stat_w[NUM_CH-1-i] = pend[i];
  end

  logic [DATA_W-1:0] rd_word, rd_sh;
  always_comb begin
    rd_word = '1;
    case ({rd_eff_q[EFF_W-1:2], 2'b00})
      OFS_CTRL:  rd_word = ctl_q;
      OFS_STAT:  rd_word = stat_w;
      OFS_PAGE:  rd_word = DATA_W'(page_q);
      OFS_CODEC: rd_word = codec_q;
      OFS_SCTL:  rd_word = sctl_q;
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if ({rd_eff_q[EFF_W-1:2], 2'b00} == sc_ofs(c))          rd_word = sc_w[c];
          if ({rd_eff_q[EFF_W-1:2], 2'b00} == fa_ofs(c))          rd_word = fa_w[c];
          if ({rd_eff_q[EFF_W-1:2], 2'b00} == fa_ofs(c) + 12'd4)  rd_word = fc_w[c];
        end
      end
    endcase
    rd_sh = rd_word >> {rd_eff_q[1:0], 3'b000};
    case (rd_size_q)
      SZ_BYTE: rd_data = (rd_eff_q == OFS_MAGIC) ? 32'h5 : (rd_sh & 32'h0000_00FF);
      SZ_HALF: rd_data = rd_sh & 32'h0000_FFFF;
      default: rd_data = rd_sh;
    endcase
  end

  assign ctl_o  = ctl_q;
  assign sctl_o = sctl_q;

  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_page |=> $stable(page_q));
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_q));
  p_sctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sctl |=> $stable(sctl_q));
endmodule

// File: tb/sim_audio_regfile.sv
module sim_audio_regfile;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [1:0]  bus_size = 2;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, rd_data, ctl_o, sctl_o;
  logic [2:0]  eng_done = 0;
  logic        irq;
  logic [95:0] ch_scount, ch_faddr, ch_fcnt;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_regfile u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = s;
    @(negedge clk);
    d = rd_data;
    bus_valid = 0;
  endtask

  task automatic pulse(logic [2:0] v);
    @(negedge clk); eng_done = v;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h00, 2, d); chk("R1 ctl", d, 32'h1);
    rd(8'h04, 2, d); chk("R1 status", d, 32'h60);
    rd(8'h0C, 2, d); chk("R1 page", d, 0);
    rd(8'h10, 2, d); chk("R1 codec", d, 0);
    rd(8'h20, 2, d); chk("R1 sctl", d, 0);
  endtask

  task automatic t_lanes();
    logic [31:0] d;
    wr(8'h02, 0, 32'hAB);
    rd(8'h00, 2, d); chk("R3 byte merge", d, 32'h00AB0001);
    wr(8'h02, 1, 32'h1234);
    rd(8'h00, 2, d); chk("R3 half merge", d, 32'h12340001);
    rd(8'h03, 0, d); chk("R3 byte read", d, 32'h12);
    rd(8'h00, 1, d); chk("R3 half read", d, 32'h0001);
    chk("R11 ctl_o", ctl_o, 32'h12340001);
    wr(8'h10, 2, 32'hCAFEF00D);
    rd(8'h10, 2, d); chk("R2 codec", d, 32'hCAFEF00D);
  endtask

  task automatic t_page();
    logic [31:0] d;
    rd(8'h30, 2, d); chk("R9 page0 window unmapped", d, 32'hFFFFFFFF);
    wr(8'h0C, 2, 32'hFFFFFFFC);
    rd(8'h0C, 2, d); chk("R5 page low bits", d, 32'hC);
    wr(8'h30, 2, 32'hDEADBEEF);
    chk("R4 dac1 faddr", ch_faddr[31:0], 32'hDEADBEEF);
    wr(8'h3C, 2, 32'h11112222);
    chk("R4 dac2 fcnt", ch_fcnt[63:32], 32'h11112222);
    rd(8'h3E, 1, d); chk("R4 dac2 fcnt hi", d, 32'h1111);
    wr(8'h0C, 2, 32'hD);
    wr(8'h34, 2, 32'h0000ABCD);
    chk("R4 adc fcnt", ch_fcnt[95:64], 32'h0000ABCD);
    rd(8'h38, 2, d); chk("R9 phantom read", d, 32'hFFFFFFFF);
    wr(8'h3C, 2, 32'h55);
    rd(8'h34, 2, d); chk("R9 phantom write ignored", d, 32'h0000ABCD);
    chk("R9 dac2 untouched", ch_fcnt[63:32], 32'h11112222);
    wr(8'h0C, 2, 32'h0);
  endtask

  task automatic t_scount();
    logic [31:0] d;
    wr(8'h28, 2, 32'hAAAA5555);
    chk("R6 dac2 scount", ch_scount[63:32], 32'h00005555);
    rd(8'h28, 2, d); chk("R6 scount read", d, 32'h00005555);
    chk("R11 dac1 scount", ch_scount[31:0], 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h20, 2, 32'h700);
    pulse(3'b001);
    chk("R7 irq dac1", {31'b0, irq}, 1);
    rd(8'h04, 2, d); chk("R7 status dac1", d, 32'h80000064);
    wr(8'h20, 2, 32'h300);
    pulse(3'b100);
    rd(8'h04, 2, d); chk("R7 adc gated", d, 32'h80000064);
    pulse(3'b010);
    rd(8'h04, 2, d); chk("R7 status dac2", d, 32'h80000066);
    wr(8'h21, 0, 32'h04);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    rd(8'h04, 2, d); chk("R8 status cleared", d, 32'h60);
    chk("R11 sctl_o", sctl_o, 32'h400);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    wr(8'h04, 2, 32'hFFFFFFFF);
    rd(8'h04, 2, d); chk("R9 status write ignored", d, 32'h60);
    rd(8'h1B, 0, d); chk("R10 magic byte", d, 32'h5);
    rd(8'h18, 2, d); chk("R9 unmapped read", d, 32'hFFFFFFFF);
    wr(8'h40, 2, 32'h0);
    rd(8'h00, 2, d); chk("R9 unmapped write ignored", d, 32'h12340001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lanes();
    t_page();
    t_scount();
    t_irq();
    t_misc();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule